// File: doc/BRIEF.md
# Two-Floor Lift Controller

This block sequences a lift car that serves two landings. The car waits at a landing with its door open and the motor idle. It leaves only when two things hold in the same clock cycle: a request for the other landing and a door-closed indication. Once it is travelling, it keeps the motor running until the arrival sensor of the destination landing fires, and then it parks there with the door open again.

The outputs are a Moore decode of the state, so each one is a function of the state alone. A parameter places the output decode either after the state register or on the next-state value with its own flops. Both placements give the same cycle timing at the ports. Requests for the landing the car already occupies are ignored. Sensor pulses from the landing the car is leaving are also ignored. If the state register ever holds an undefined value, the motor stays off and the controller recovers to the lower landing.

Top module: `lift2_ctrl`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, the car is at the lower landing: `door_open`=1, `motor_up`=0, `motor_down`=0.
- R2: While parked at either landing, `door_open`=1 and both motor outputs are 0.
- R3: At the lower landing, the car starts upward at the next rising edge only when `req_upper` and `door_shut` are both 1 in that cycle. Either one alone leaves the car parked.
- R4: At the upper landing, the car starts downward at the next rising edge only when `req_lower` and `door_shut` are both 1 in that cycle. Either one alone leaves the car parked.
- R5: While travelling up, only `motor_up` is 1 and `door_open` is 0. Requests and `door_shut` have no effect on this.
- R6: Upward travel ends at the edge where `arrive_upper` is 1, and the car then parks at the upper landing. `arrive_lower` during upward travel is ignored.
- R7: While travelling down, only `motor_down` is 1 and `door_open` is 0. The travel ends at the edge where `arrive_lower` is 1, and the car then parks at the lower landing. `arrive_upper` during downward travel is ignored.
- R8: A request for the landing the car occupies is ignored, even when `door_shut` is 1. The car stays parked with the door open.
- R9: `motor_up` and `motor_down` are never 1 together. An undefined state value drives both motor outputs to 0 and returns the car to the lower landing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_lower | input | 1 | Request to serve the lower landing |
| req_upper | input | 1 | Request to serve the upper landing |
| door_shut | input | 1 | Door reports closed; permits departure |
| arrive_lower | input | 1 | Arrival sensor at the lower landing |
| arrive_upper | input | 1 | Arrival sensor at the upper landing |
| motor_up | output | 1 | Drive the car upward |
| motor_down | output | 1 | Drive the car downward |
| door_open | output | 1 | Hold the door open |

## Verification
The hardest case to reach from the ports is a sensor pulse from the wrong landing while the car is travelling. The car must first be sent off with the correct request and door-closed pair, and the pulse must then arrive between departure and arrival. The stimulus does this by firing each wrong sensor for a cycle in the middle of a trip. It also fires both sensors together, and it fires the departure pair alongside a stale sensor at a parked landing. A reset is applied in the middle of a trip to confirm that the car recovers to the lower landing.

// File: rtl/lift2_pkg.sv
package lift2_pkg;

   // One-hot state codes; any other pattern is illegal and is recovered.
   localparam int unsigned ST_W = 4;

   typedef enum logic [ST_W-1:0] {
      PARK_LO = 4'b0001,
      PARK_HI = 4'b0010,
      RUN_UP  = 4'b0100,
      RUN_DN  = 4'b1000
   } lift_st_e;

   typedef struct packed {
      logic up;
      logic dn;
      logic door;
   } lift_drv_t;

   localparam lift_drv_t DRV_SAFE  = '{up: 1'b0, dn: 1'b0, door: 1'b0};
   localparam lift_drv_t DRV_PARK  = '{up: 1'b0, dn: 1'b0, door: 1'b1};

endpackage

// File: rtl/lift2_next.sv
module lift2_next
   import lift2_pkg::*;
(
   input  lift_st_e cur,
   input  logic     req_lo,
   input  logic     req_hi,
   input  logic     shut,
   input  logic     at_lo,
   input  logic     at_hi,
   output lift_st_e nxt
);

   always_comb begin
      unique case (cur)
         PARK_LO: nxt = (req_hi && shut) ? RUN_UP : PARK_LO;
         PARK_HI: nxt = (req_lo && shut) ? RUN_DN : PARK_HI;
         RUN_UP:  nxt = at_hi ? PARK_HI : RUN_UP;
         RUN_DN:  nxt = at_lo ? PARK_LO : RUN_DN;
         default: nxt = PARK_LO;
      endcase
   end

endmodule

// File: rtl/lift2_decode.sv
module lift2_decode
   import lift2_pkg::*;
(
   input  lift_st_e  st,
   output lift_drv_t drv
);

   always_comb begin
      unique case (st)
         PARK_LO, PARK_HI: drv = DRV_PARK;
         RUN_UP:           drv = '{up: 1'b1, dn: 1'b0, door: 1'b0};
         RUN_DN:           drv = '{up: 1'b0, dn: 1'b1, door: 1'b0};
         default:          drv = DRV_SAFE;
      endcase
   end

   // R9: the decode never drives both motor directions
   always_comb begin
      assert_decode_excl_R9: assert (!(drv.up && drv.dn));
   end

endmodule

// File: rtl/lift2_ctrl.sv
module lift2_ctrl
   import lift2_pkg::*;
#(
   parameter int unsigned REG_OUTPUTS = 0
)(
   input  logic clk,
   input  logic rst_n,
   input  logic req_lower,
   input  logic req_upper,
   input  logic door_shut,
   input  logic arrive_lower,
   input  logic arrive_upper,
   output logic motor_up,
   output logic motor_down,
   output logic door_open
);

   if (REG_OUTPUTS > 1) begin : g_bad_param
      $error("REG_OUTPUTS must be 0 or 1");
   end

   lift_st_e  st_q;
   lift_st_e  st_d;
   lift_drv_t drv;

   lift2_next u_next (
      .cur    (st_q),
      .req_lo (req_lower),
      .req_hi (req_upper),
      .shut   (door_shut),
      .at_lo  (arrive_lower),
      .at_hi  (arrive_upper),
      .nxt    (st_d)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st_q <= PARK_LO;
      else        st_q <= st_d;
   end

   if (REG_OUTPUTS == 1) begin : g_reg_out
      // Decode the next state and capture it, so outputs leave flops
      lift_drv_t drv_d;
      lift2_decode u_dec (.st(st_d), .drv(drv_d));
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) drv <= DRV_PARK;
         else        drv <= drv_d;
      end
   end else begin : g_comb_out
      lift2_decode u_dec (.st(st_q), .drv(drv));
   end

   assign motor_up   = drv.up;
   assign motor_down = drv.dn;
   assign door_open  = drv.door;

   // R9: motor directions are exclusive at the ports
   assert_motor_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !(motor_up && motor_down));

   // R2: an open door means the motor is idle
   assert_door_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
      door_open |-> (!motor_up && !motor_down));

   // R3: departure upward from the lower landing
   assert_depart_up_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == PARK_LO && req_upper && door_shut) |=> motor_up);

   // R8: a request for the occupied landing keeps the door open
   assert_stay_lo_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == PARK_LO && !req_upper) |=> door_open);

   // R5: upward travel continues until the upper sensor fires
   assert_hold_up_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (motor_up && !arrive_upper) |=> motor_up);

   // R6: arrival at the upper landing parks the car
   assert_arrive_hi_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (motor_up && arrive_upper) |=> (door_open && !motor_up));

   // R7: downward travel ends only on the lower sensor
   assert_hold_dn_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (motor_down && !arrive_lower) |=> motor_down);

endmodule

// File: tb/test_lift2_ctrl.sv
`timescale 1ns/1ps
module test_lift2_ctrl;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic req_lower = 0, req_upper = 0, door_shut = 0;
   logic arrive_lower = 0, arrive_upper = 0;
   logic motor_up, motor_down, door_open;

   int n_chk = 0;
   int n_err = 0;

   typedef struct {
      logic [2:0] exp;   // {up, down, door}
      string      tag;
   } item_t;

   item_t sbq[$];
   bit    done = 0;

   always #4 clk = ~clk;   // 125 MHz

   lift2_ctrl i_lift2_ctrl (
      .clk(clk), .rst_n(rst_n),
      .req_lower(req_lower), .req_upper(req_upper), .door_shut(door_shut),
      .arrive_lower(arrive_lower), .arrive_upper(arrive_upper),
      .motor_up(motor_up), .motor_down(motor_down), .door_open(door_open)
   );

   task automatic check(input logic [2:0] exp, input string tag);
      logic [2:0] act;
      act = {motor_up, motor_down, door_open};
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: {up,down,door} actual=%b expected=%b", tag, act, exp);
      end
   endtask

   // Driver: apply inputs away from the edge, queue the outcome after it
   task automatic drv(input logic lo, hi, sh, alo, ahi,
                      input logic [2:0] exp, input string tag);
      item_t it;
      @(negedge clk);
      req_lower = lo; req_upper = hi; door_shut = sh;
      arrive_lower = alo; arrive_upper = ahi;
      @(posedge clk);
      it.exp = exp;
      it.tag = tag;
      sbq.push_back(it);
   endtask

   // Monitor: compare after each edge
   initial begin
      forever begin
         @(posedge clk);
         #2;
         if (sbq.size() > 0) begin
            item_t it;
            it = sbq.pop_front();
            check(it.exp, it.tag);
            n_chk++;
            if (motor_up && motor_down) begin
               n_err++;
               $display("FAIL R9: both motors on, actual=11 expected=not 11");
            end
         end
      end
   end

   localparam logic [2:0] PARK = 3'b001;
   localparam logic [2:0] UP   = 3'b100;
   localparam logic [2:0] DN   = 3'b010;

   initial begin
      #20;
      check(PARK, "R1 in reset");
      @(negedge clk);
      rst_n = 1'b1;
      @(posedge clk); #2;
      check(PARK, "R1 after release");

      drv(1,0,1,0,0, PARK, "R8 lower request at lower");
      drv(0,1,0,0,0, PARK, "R3 request without shut");
      drv(0,0,1,0,0, PARK, "R3 shut without request");
      drv(0,1,1,0,0, UP,   "R3 depart up");
      drv(0,0,0,0,0, UP,   "R5 hold up");
      drv(0,0,0,1,0, UP,   "R6 wrong sensor ignored");
      drv(1,0,1,0,0, UP,   "R5 request ignored in travel");
      drv(0,0,0,0,1, PARK, "R6 arrive upper");
      drv(0,1,1,0,0, PARK, "R8 upper request at upper");
      drv(1,0,0,0,0, PARK, "R4 request without shut");
      drv(0,0,1,0,0, PARK, "R2 parked upper");
      drv(1,0,1,0,0, DN,   "R4 depart down");
      drv(0,0,0,0,1, DN,   "R7 wrong sensor ignored");
      drv(0,1,1,0,0, DN,   "R7 hold down");
      drv(0,0,0,1,0, PARK, "R7 arrive lower");
      drv(0,1,1,0,1, UP,   "R3 depart with stale sensor");
      drv(0,0,0,1,1, PARK, "R6 both sensors");
      drv(1,0,1,0,0, DN,   "R4 depart again");
      drv(0,0,0,0,0, DN,   "R7 travelling");
      @(negedge clk);
      req_lower = 0; door_shut = 0;
      rst_n = 1'b0;
      #1;
      check(PARK, "R1 reset mid-travel");
      @(negedge clk);
      rst_n = 1'b1;
      drv(1,0,1,0,0, PARK, "R8 after reset at lower");
      drv(0,1,1,0,0, UP,   "R1 recovered to lower");
      @(negedge clk);
      @(negedge clk);
      done = 1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (2000) @(posedge clk);
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual=timeout expected=finish");
         end
      join_any
      $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

endmodule